// File: doc/BRIEF.md
# Eight-Bit Timer With Selectable Counter Clear

This block is an eight-bit up-counter with two compare registers, three sticky event flags and two gated interrupt requests. Software reaches it through a plain register port. The counter advances by one on every clock cycle in which the count-enable input is high. A two-bit field in the control register sets what returns the counter to zero. The choices are no clearing, a match on compare A, a match on compare B, or an external reset pin.

When the external pin is selected, a separate mode bit sets how the pin acts. With the mode bit at 0, the counter clears once on each rising edge of the pin. With the mode bit at 1, the counter is held at zero for as long as the pin stays high. The pin passes through a two-flop synchronizer before it is used.

A clear caused by a compare match takes effect on the count after the match. The counter therefore holds the compare value for one full count period before it returns to zero. Event flags are sticky. Software can clear a flag only by reading it as 1 and then writing 0 to it.

Top module: `tick8_timer`

## Requirements
- R1: After reset, the counter, both compare registers, the control register (address 3) and the status register (address 4) all read 0, and both interrupt outputs are low.
- R2: On each cycle with `countEn` high, the counter (address 0) increases by one. When it steps from 0xFF to 0x00, status bit 2 (overflow) sets. With `countEn` low, the counter holds its value.
- R3: On a count cycle in which the counter equals compare A (address 1), status bit 0 sets. On a count cycle in which it equals compare B (address 2), status bit 1 sets.
- R4: With control bits 5:4 = 01, the counter clears on the count that follows a match with compare A. It therefore shows the compare value for exactly one count.
- R5: With control bits 5:4 = 10, the counter clears on the count that follows a match with compare B.
- R6: With control bits 5:4 = 00, a compare match does not clear the counter. The counter counts past the compare value.
- R7: With control bits 5:4 = 11 and control bit 3 = 0, a rising edge on `extRst` clears the counter once, by the third clock edge. While `extRst` stays high, a later write to the counter still takes effect.
- R8: With control bits 5:4 = 11 and control bit 3 = 1, the counter is held at 0 while the synchronized `extRst` is high, and this overrides software writes. Once the pin has been low for three clocks, writes take effect again.
- R9: A clear takes priority over an increment in the same cycle. A compare clear at 0xFF does not set the overflow flag.
- R10: A status flag clears only when 0 is written to its bit after a status read that returned that bit as 1. A write of 0 without a prior read leaves the flag set, and so does a write of 1.
- R11: `irqCmpA` is high exactly when status bit 0 and control bit 7 are both 1. `irqOvf` is high exactly when status bit 2 and control bit 6 are both 1.
- R12: The control register reads back every bit written to it. Bits 2:0 are stored but do not change the counting rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Count enable: one increment per high cycle |
| extRst | input | 1 | Asynchronous external clear input |
| regAddr | input | 3 | Register address: 0 counter, 1 compare A, 2 compare B, 3 control, 4 status |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (arms flag clearing) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from the address |
| irqCmpA | output | 1 | Compare-A interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
A wrong clear decision appears on the counter read-back at the very next count. The counter either shows a value one above the compare register, or shows zero one count too early. An error in the synchronizer or the edge tracking shows up as a change of one clock in the third-edge clear, or as a second clear while the pin stays high. Flag and arming mistakes are visible immediately on the interrupt outputs, because those outputs follow the stored flags with no added delay.

// File: rtl/tick8_pkg.sv
package tick8_pkg;

  localparam logic [2:0] ADDR_CNT  = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_CMPB = 3'd2;
  localparam logic [2:0] ADDR_CTRL = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;

  // control register bit positions
  localparam int CTL_IE_A   = 7;
  localparam int CTL_IE_OVF = 6;
  localparam int CTL_CLR_HI = 5;
  localparam int CTL_CLR_LO = 4;
  localparam int CTL_EXTLVL = 3;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMPA = 2'b01,
    CLR_CMPB = 2'b10,
    CLR_EXT  = 2'b11
  } clrSel_e;

  typedef struct packed {
    logic clrExt;
    logic clrMatch;
    logic incCnt;
    logic setOvf;
    logic setB;
    logic setA;
  } tmrStrobe_t;

endpackage

// File: rtl/tick8_ctrl.sv
module tick8_ctrl
  import tick8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       countEn,
  input  logic       extRst,
  input  logic       cntWrite,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       cntAtMax,
  input  clrSel_e    clrSel,
  input  logic       extLevel,
  output tmrStrobe_t strb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extNow;
  logic                   extPrev;
  logic                   extHit;
  logic                   matchHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extRst};
      extPrev <= extNow;
    end
  end

  assign extNow = syncQ[SYNC_STAGES-1];

  always_comb begin
    extHit   = (clrSel == CLR_EXT) && (extLevel ? extNow : (extNow && !extPrev));
    matchHit = countEn && (((clrSel == CLR_CMPA) && matchA) ||
                           ((clrSel == CLR_CMPB) && matchB));
    strb.clrExt   = extHit;
    strb.clrMatch = matchHit && !extHit && !cntWrite;
    strb.incCnt   = countEn && !extHit && !cntWrite && !matchHit;
    strb.setOvf   = countEn && !extHit && !cntWrite && !matchHit && cntAtMax;
    strb.setA     = countEn && matchA;
    strb.setB     = countEn && matchB;
  end

endmodule

// File: rtl/tick8_dpath.sv
module tick8_dpath
  import tick8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strb,
  input  logic [2:0]   regAddr,
  input  logic         regWr,
  input  logic         regRd,
  input  logic [W-1:0] regWdata,
  output logic [W-1:0] regRdata,
  output logic         cntWrite,
  output logic         matchA,
  output logic         matchB,
  output logic         cntAtMax,
  output clrSel_e      clrSel,
  output logic         extLevel,
  output logic         irqCmpA,
  output logic         irqOvf
);

  localparam int NFLAG = 3;

  logic [W-1:0]     cntQ;
  logic [W-1:0]     cmpAQ;
  logic [W-1:0]     cmpBQ;
  logic [W-1:0]     ctrlQ;
  logic [NFLAG-1:0] flagQ;
  logic [NFLAG-1:0] armedQ;
  logic [NFLAG-1:0] setVec;
  logic             statWr;
  logic             statRd;

  assign cntWrite = regWr && (regAddr == ADDR_CNT);
  assign statWr   = regWr && (regAddr == ADDR_STAT);
  assign statRd   = regRd && (regAddr == ADDR_STAT);
  assign setVec   = {strb.setOvf, strb.setB, strb.setA};

  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strb.clrExt)     cntQ <= '0;
    else if (cntWrite)        cntQ <= regWdata;
    else if (strb.clrMatch)   cntQ <= '0;
    else if (strb.incCnt)     cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpAQ <= '0;
      cmpBQ <= '0;
      ctrlQ <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_CMPA) cmpAQ <= regWdata;
      if (regAddr == ADDR_CMPB) cmpBQ <= regWdata;
      if (regAddr == ADDR_CTRL) ctrlQ <= regWdata;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : gFlag
    logic clrNow;
    assign clrNow = statWr && !regWdata[i] && armedQ[i];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[i]  <= 1'b0;
        armedQ[i] <= 1'b0;
      end else begin
        if (setVec[i])   flagQ[i] <= 1'b1;
        else if (clrNow) flagQ[i] <= 1'b0;
        if (statRd && flagQ[i]) armedQ[i] <= 1'b1;
        else if (clrNow)        armedQ[i] <= 1'b0;
      end
    end
  end

  assign matchA   = (cntQ == cmpAQ);
  assign matchB   = (cntQ == cmpBQ);
  assign cntAtMax = &cntQ;
  assign clrSel   = clrSel_e'(ctrlQ[CTL_CLR_HI:CTL_CLR_LO]);
  assign extLevel = ctrlQ[CTL_EXTLVL];
  assign irqCmpA  = flagQ[0] && ctrlQ[CTL_IE_A];
  assign irqOvf   = flagQ[2] && ctrlQ[CTL_IE_OVF];

  always_comb begin
    case (regAddr)
      ADDR_CNT:  regRdata = cntQ;
      ADDR_CMPA: regRdata = cmpAQ;
      ADDR_CMPB: regRdata = cmpBQ;
      ADDR_CTRL: regRdata = ctrlQ;
      ADDR_STAT: regRdata = {{(W-NFLAG){1'b0}}, flagQ};
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/tick8_timer.sv
module tick8_timer
  import tick8_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         countEn,
  input  logic         extRst,
  input  logic [2:0]   regAddr,
  input  logic         regWr,
  input  logic         regRd,
  input  logic [W-1:0] regWdata,
  output logic [W-1:0] regRdata,
  output logic         irqCmpA,
  output logic         irqOvf
);

  tmrStrobe_t strb;
  logic       cntWrite;
  logic       matchA;
  logic       matchB;
  logic       cntAtMax;
  clrSel_e    clrSel;
  logic       extLevel;

  tick8_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .countEn(countEn), .extRst(extRst),
    .cntWrite(cntWrite), .matchA(matchA), .matchB(matchB),
    .cntAtMax(cntAtMax), .clrSel(clrSel), .extLevel(extLevel), .strb(strb)
  );

  tick8_dpath #(.W(W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .cntWrite(cntWrite), .matchA(matchA), .matchB(matchB),
    .cntAtMax(cntAtMax), .clrSel(clrSel), .extLevel(extLevel),
    .irqCmpA(irqCmpA), .irqOvf(irqOvf)
  );

endmodule

// File: rtl/tick8_chk.sv
module tick8_chk
  import tick8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input tmrStrobe_t   strb,
  input logic [W-1:0] cntQ,
  input logic [W-1:0] ctrlQ,
  input logic [2:0]   flagQ,
  input logic         regWr,
  input logic [2:0]   regAddr,
  input logic         irqCmpA,
  input logic         irqOvf
);

  // R2
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && (&cntQ)) |=> (cntQ == '0) && flagQ[2]);

  // R3
  flag_a_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setA |=> flagQ[0]);

  // R4
  match_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMatch |=> (cntQ == '0));

  // R8
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrExt |=> (cntQ == '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ[2] && !strb.incCnt) |=> !flagQ[2]);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[0] && !(regWr && (regAddr == ADDR_STAT))) |=> flagQ[0]);

  // R11
  irq_a_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqCmpA |-> (flagQ[0] && ctrlQ[CTL_IE_A]));

  // R11
  irq_ovf_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOvf |-> (flagQ[2] && ctrlQ[CTL_IE_OVF]));

endmodule

bind tick8_dpath tick8_chk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .cntQ(cntQ), .ctrlQ(ctrlQ),
  .flagQ(flagQ), .regWr(regWr), .regAddr(regAddr),
  .irqCmpA(irqCmpA), .irqOvf(irqOvf)
);

// File: tb/tb_tick8_timer.sv
`timescale 1ns/1ps
module tb_tick8_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countEn = 1'b0;
  logic       extRst = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irqCmpA;
  logic       irqOvf;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  tick8_timer dut (
    .clk(clk), .rstN(rstN), .countEn(countEn), .extRst(extRst),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irqCmpA(irqCmpA), .irqOvf(irqOvf)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] v);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic countN(input int n);
    countEn = 1'b1;
    repeat (n) @(negedge clk);
    countEn = 1'b0;
  endtask

  task automatic clearFlags();
    logic [7:0] v;
    rdReg(3'd4, v);
    wrReg(3'd4, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      rdReg(3'(a), v);
      check("R1", $sformatf("reg %0d after reset", a), v, 8'h00);
    end
    check("R1", "irqCmpA after reset", {7'd0, irqCmpA}, 8'h00);
    check("R1", "irqOvf after reset", {7'd0, irqOvf}, 8'h00);
  endtask

  task automatic testWrap();
    logic [7:0] v;
    wrReg(3'd3, 8'h00);
    wrReg(3'd0, 8'hFD);
    countN(2);
    rdReg(3'd0, v);  check("R2", "count to FF", v, 8'hFF);
    rdReg(3'd4, v);  check("R2", "no ovf before wrap", v & 8'h04, 8'h00);
    repeat (3) @(negedge clk);
    rdReg(3'd0, v);  check("R2", "hold with countEn low", v, 8'hFF);
    countN(1);
    rdReg(3'd0, v);  check("R2", "wrap to 00", v, 8'h00);
    rdReg(3'd4, v);  check("R2", "ovf set on wrap", v & 8'h04, 8'h04);
  endtask

  task automatic testIrqOvf();
    wrReg(3'd3, 8'h40);
    check("R11", "irqOvf enabled", {7'd0, irqOvf}, 8'h01);
    wrReg(3'd3, 8'h00);
    check("R11", "irqOvf disabled", {7'd0, irqOvf}, 8'h00);
  endtask

  task automatic testNoClear();
    logic [7:0] v;
    clearFlags();
    wrReg(3'd3, 8'h00);
    wrReg(3'd1, 8'h03);
    wrReg(3'd0, 8'h00);
    countN(5);
    rdReg(3'd0, v);  check("R6", "counts past compare A", v, 8'h05);
    rdReg(3'd4, v);  check("R3", "flag A set on match", v & 8'h01, 8'h01);
  endtask

  task automatic testClrA();
    logic [7:0] v;
    clearFlags();
    wrReg(3'd1, 8'h05);
    wrReg(3'd2, 8'h80);
    wrReg(3'd3, 8'h10);
    wrReg(3'd0, 8'h00);
    countN(5);
    rdReg(3'd0, v);  check("R4", "holds compare A value", v, 8'h05);
    rdReg(3'd4, v);  check("R4", "flag A not yet set", v & 8'h01, 8'h00);
    countN(1);
    rdReg(3'd0, v);  check("R4", "cleared after match A", v, 8'h00);
    rdReg(3'd4, v);  check("R3", "flag A set at clear", v & 8'h01, 8'h01);
    countN(1);
    rdReg(3'd0, v);  check("R4", "counts again from 0", v, 8'h01);
  endtask

  task automatic testClrB();
    logic [7:0] v;
    clearFlags();
    wrReg(3'd1, 8'h02);
    wrReg(3'd2, 8'h04);
    wrReg(3'd3, 8'h20);
    wrReg(3'd0, 8'h00);
    countN(4);
    rdReg(3'd0, v);  check("R5", "passes A, holds B value", v, 8'h04);
    countN(1);
    rdReg(3'd0, v);  check("R5", "cleared after match B", v, 8'h00);
    rdReg(3'd4, v);  check("R3", "flag B set", v & 8'h02, 8'h02);
  endtask

  task automatic testClearWins();
    logic [7:0] v;
    wrReg(3'd3, 8'h00);
    clearFlags();
    wrReg(3'd1, 8'hFF);
    wrReg(3'd2, 8'h80);
    wrReg(3'd3, 8'h10);
    wrReg(3'd0, 8'hFE);
    countN(1);
    rdReg(3'd0, v);  check("R9", "reaches FF", v, 8'hFF);
    countN(1);
    rdReg(3'd0, v);  check("R9", "match clear at FF", v, 8'h00);
    rdReg(3'd4, v);  check("R9", "no ovf from match clear", v & 8'h05, 8'h01);
  endtask

  task automatic testFlagClear();
    logic [7:0] v;
    wrReg(3'd3, 8'h00);
    clearFlags();
    wrReg(3'd1, 8'h02);
    wrReg(3'd2, 8'h80);
    wrReg(3'd0, 8'h00);
    wrReg(3'd3, 8'h80);
    countN(3);
    check("R11", "irqCmpA with flag and enable", {7'd0, irqCmpA}, 8'h01);
    wrReg(3'd4, 8'h00);
    check("R10", "write 0 without read keeps flag", {7'd0, irqCmpA}, 8'h01);
    wrReg(3'd3, 8'h00);
    check("R11", "irqCmpA gated off", {7'd0, irqCmpA}, 8'h00);
    wrReg(3'd3, 8'h80);
    rdReg(3'd4, v);  check("R10", "flag A reads 1", v & 8'h01, 8'h01);
    wrReg(3'd4, 8'hFF);
    check("R10", "write 1 keeps flag", {7'd0, irqCmpA}, 8'h01);
    wrReg(3'd4, 8'h00);
    check("R10", "read then write 0 clears", {7'd0, irqCmpA}, 8'h00);
    rdReg(3'd4, v);  check("R10", "status bit 0 clear", v & 8'h01, 8'h00);
  endtask

  task automatic testExtEdge();
    logic [7:0] v;
    wrReg(3'd3, 8'h30);
    wrReg(3'd0, 8'h55);
    extRst = 1'b1;
    repeat (2) @(negedge clk);
    rdReg(3'd0, v);  check("R7", "no clear before third edge", v, 8'h55);
    rdReg(3'd0, v);  check("R7", "cleared by rising edge", v, 8'h00);
    wrReg(3'd0, 8'h33);
    rdReg(3'd0, v);  check("R7", "high level alone does not clear", v, 8'h33);
    extRst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testExtLevel();
    logic [7:0] v;
    wrReg(3'd3, 8'h38);
    wrReg(3'd0, 8'h44);
    rdReg(3'd0, v);  check("R8", "no clear while low", v, 8'h44);
    extRst = 1'b1;
    repeat (3) @(negedge clk);
    rdReg(3'd0, v);  check("R8", "cleared while high", v, 8'h00);
    wrReg(3'd0, 8'h33);
    rdReg(3'd0, v);  check("R8", "write overridden while high", v, 8'h00);
    extRst = 1'b0;
    repeat (3) @(negedge clk);
    wrReg(3'd0, 8'h22);
    rdReg(3'd0, v);  check("R8", "write works after release", v, 8'h22);
  endtask

  task automatic testCtrlReadback();
    logic [7:0] v;
    wrReg(3'd3, 8'h07);
    rdReg(3'd3, v);  check("R12", "control readback", v, 8'h07);
    wrReg(3'd0, 8'h10);
    countN(2);
    rdReg(3'd0, v);  check("R12", "bits 2:0 leave rate at one", v, 8'h12);
    wrReg(3'd1, 8'hA5);
    rdReg(3'd1, v);  check("R12", "compare A readback", v, 8'hA5);
    wrReg(3'd2, 8'h5A);
    rdReg(3'd2, v);  check("R12", "compare B readback", v, 8'h5A);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrap();
    testIrqOvf();
    testNoClear();
    testClrA();
    testClrB();
    testClearWins();
    testFlagClear();
    testExtEdge();
    testExtLevel();
    testCtrlReadback();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule